// File: doc/BRIEF.md
# Transmit Descriptor Process Controller

This block is the control state machine for the transmit side of a descriptor-ring DMA engine. A single enable input starts and stops the transmit process. The block keeps the process in one of three states: Stopped, Running or Suspended. While Running it reads descriptors from a ring in memory through a request/acknowledge port. Each response carries an ownership bit, an end-of-ring flag and the buffer address and length.

When a descriptor is owned by the engine, its buffer details go to a frame mover and the ring position advances. When the mover reports completion, the block issues a write-back that hands the descriptor back to software. When a descriptor is not owned, the process suspends and raises a sticky buffer-unavailable flag. A poll pulse makes the block read that descriptor again. A stop lets the frames already handed over finish, and it keeps the ring position so that the next start resumes from there. An optional second-frame mode lets the block hand over a second frame before the first one has finished.

Top module: `txq_proc_ctl`

## Requirements
- R1: After reset, proc_state is 00 (Stopped), and rd_req, mv_start, wb_valid and buf_unavail are all low.
- R2: When run_en is high while Stopped, proc_state becomes 01 (Running) at the next edge and a descriptor read is requested at once. On the first start after reset the read address is base_addr.
- R3: An acknowledged descriptor with rd_own=1 produces a one-cycle mv_start carrying its buffer address and length. The ring position then advances by 16 bytes, or returns to base_addr when rd_eor=1. rd_addr and rd_req stay stable until rd_ack.
- R4: An acknowledged descriptor with rd_own=0 moves the process to 10 (Suspended) and sets buf_unavail.
- R5: run_en low while Running or Suspended stops new descriptor reads. The state goes to 00 only after every handed-over frame has reported mv_done and no read is pending.
- R6: A start after a stop resumes reading at the descriptor that follows the last one handed over, not at base_addr.
- R7: While Stopped, a low run_en and poll pulses cause no read and leave the state at 00.
- R8: With second_frame_en=0, at most one frame is outstanding. With second_frame_en=1, at most two are outstanding, and a second frame is handed over before the first completes.
- R9: Each mv_done for an outstanding frame produces one wb_valid pulse whose wb_addr is the descriptor address of that frame, in hand-over order.
- R10: A poll_req pulse while Suspended re-reads the current descriptor. If it is now owned the process returns to Running and sends it. If not, the process stays Suspended with buf_unavail set.
- R11: An unavail_clr pulse clears buf_unavail. A set in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | Ring base address |
| run_en | input | 1 | Transmit enable (start when high, stop when low) |
| second_frame_en | input | 1 | Allow two outstanding frames |
| poll_req | input | 1 | One-cycle poll demand |
| unavail_clr | input | 1 | Write-one-to-clear for buf_unavail |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor address being read |
| rd_ack | input | 1 | Read response valid |
| rd_own | input | 1 | Descriptor owned by the engine |
| rd_eor | input | 1 | Descriptor is last in the ring |
| rd_buf_addr | input | AW | Buffer address from the descriptor |
| rd_buf_len | input | LW | Buffer length from the descriptor |
| mv_start | output | 1 | One-cycle frame hand-over pulse |
| mv_addr | output | AW | Buffer address of the handed-over frame |
| mv_len | output | LW | Buffer length of the handed-over frame |
| mv_done | input | 1 | Frame mover completion pulse |
| wb_valid | output | 1 | Clear ownership of the descriptor at wb_addr |
| wb_addr | output | AW | Descriptor address to write back |
| proc_state | output | 2 | 00 Stopped, 01 Running, 10 Suspended |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |

## Verification
The bench sweeps the number of owned descriptors from none to a full ring. It does this for both frame-limit modes and for a short and a long mover latency, and it checks the final ring position against arithmetic. A wrong wrap or step would leave the final read address off the expected value. A stop that does not drain would drop to Stopped while a frame is still in flight, or lose write-backs. A restart that reloads the base address would send descriptor zero again, and the in-order check on mv_addr would catch it. A limit error would show up as an outstanding count of two in single mode, or never reaching two in second-frame mode with a slow mover.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [1:0] {
        PS_STOP = 2'b00,
        PS_RUN  = 2'b01,
        PS_SUSP = 2'b10
    } proc_st_e;

endpackage

// File: rtl/txq_pos_track.sv
module txq_pos_track #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          start,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] pos
);

    typedef struct packed {
        logic [AW-1:0] pos;
        logic          seeded;
    } pos_t;

    pos_t q, d;

    always_comb begin
        d = q;
        if (start && !q.seeded) begin
            d.pos    = base_addr;
            d.seeded = 1'b1;
        end else if (advance) begin
            d.pos = wrap ? base_addr : q.pos + AW'(DESC_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pos = q.pos;

endmodule

// File: rtl/txq_inflight.sv
module txq_inflight #(
    parameter int AW    = 32,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     wb_v;
        logic [AW-1:0]            wb_a;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d       = q;
        pop_ok  = pop && (q.cnt != '0);
        push_ok = push && (q.cnt != CW'(DEPTH));
        d.wb_v  = pop_ok;
        if (pop_ok) begin
            d.wb_a = q.slot[q.rp];
            d.rp   = bump(q.rp);
        end
        if (push_ok) begin
            d.slot[q.wp] = push_addr;
            d.wp         = bump(q.wp);
        end
        if (push_ok && !pop_ok)      d.cnt = q.cnt + CW'(1);
        else if (pop_ok && !push_ok) d.cnt = q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.cnt;
    assign wb_valid = q.wb_v;
    assign wb_addr  = q.wb_a;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.cnt != CW'(DEPTH)));                                  // R8
    AST_WB_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q.cnt == '0) |=> !wb_valid);                              // R9

endmodule

// File: rtl/txq_proc_ctl.sv
module txq_proc_ctl
    import txq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int DESC_BYTES = 16,
    parameter int MAX_OUT    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          run_en,
    input  logic          second_frame_en,
    input  logic          poll_req,
    input  logic          unavail_clr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic          rd_own,
    input  logic          rd_eor,
    input  logic [AW-1:0] rd_buf_addr,
    input  logic [LW-1:0] rd_buf_len,
    output logic          mv_start,
    output logic [AW-1:0] mv_addr,
    output logic [LW-1:0] mv_len,
    input  logic          mv_done,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [1:0]    proc_state,
    output logic          buf_unavail
);

    localparam int CW = $clog2(MAX_OUT + 1);

    typedef struct packed {
        proc_st_e      st;
        logic          stopping;
        logic          fetching;
        logic          unavail;
        logic          mv_start;
        logic [AW-1:0] mv_addr;
        logic [LW-1:0] mv_len;
    } ctl_t;

    ctl_t          q, d;
    logic [CW-1:0] in_cnt;
    logic [CW-1:0] lim;
    logic [AW-1:0] pos;
    logic          push, start_ev, adv, wrap, ack, halt;

    generate
        if (MAX_OUT > 1) begin : g_two_frame
            assign lim = second_frame_en ? CW'(MAX_OUT) : CW'(1);
        end else begin : g_one_frame
            assign lim = CW'(1);
        end
    endgenerate

    always_comb begin
        d          = q;
        d.mv_start = 1'b0;
        push       = 1'b0;
        start_ev   = 1'b0;
        adv        = 1'b0;
        wrap       = 1'b0;
        ack        = q.fetching && rd_ack;
        halt       = q.stopping || !run_en;
        if (ack)         d.fetching = 1'b0;
        if (unavail_clr) d.unavail  = 1'b0;
        unique case (q.st)
            PS_STOP: begin
                if (run_en) begin
                    d.st       = PS_RUN;
                    d.fetching = 1'b1;
                    start_ev   = 1'b1;
                end
            end
            default: begin
                if (!run_en) d.stopping = 1'b1;
                if (ack && !halt) begin
                    if (rd_own) begin
                        d.st       = PS_RUN;
                        push       = 1'b1;
                        adv        = 1'b1;
                        wrap       = rd_eor;
                        d.mv_start = 1'b1;
                        d.mv_addr  = rd_buf_addr;
                        d.mv_len   = rd_buf_len;
                    end else begin
                        d.st      = PS_SUSP;
                        d.unavail = 1'b1;
                    end
                end
                if (!halt && !q.fetching) begin
                    if (q.st == PS_RUN && in_cnt < lim)  d.fetching = 1'b1;
                    if (q.st == PS_SUSP && poll_req)     d.fetching = 1'b1;
                end
                if (q.stopping && !q.fetching && in_cnt == '0) begin
                    d.st       = PS_STOP;
                    d.stopping = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PS_STOP;
        end else begin
            q <= d;
        end
    end

    txq_pos_track #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_addr(base_addr),
        .start    (start_ev),
        .advance  (adv),
        .wrap     (wrap),
        .pos      (pos)
    );

    txq_inflight #(.AW(AW), .DEPTH(MAX_OUT)) u_inflight (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_addr(pos),
        .pop      (mv_done),
        .count    (in_cnt),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr)
    );

    assign rd_req      = q.fetching;
    assign rd_addr     = pos;
    assign mv_start    = q.mv_start;
    assign mv_addr     = q.mv_addr;
    assign mv_len      = q.mv_len;
    assign proc_state  = q.st;
    assign buf_unavail = q.unavail;

    AST_START_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_RUN && $past(q.st) == PS_STOP) |-> $past(run_en));    // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));            // R3
    AST_SUSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_SUSP && $past(q.st) == PS_RUN) |-> buf_unavail);      // R4
    AST_STOP_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_STOP && $past(q.st) != PS_STOP)
            |-> ($past(in_cnt) == '0 && !$past(rd_req)));                 // R5
    AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_STOP) |-> (!rd_req && !mv_start));                    // R7

endmodule

// File: tb/txq_proc_ctl_test.sv
`timescale 1ns/1ps
module txq_proc_ctl_test;
    localparam int AW   = 32;
    localparam int LW   = 16;
    localparam int RING = 8;
    localparam logic [AW-1:0] BASE = 32'h0000_4000;
    localparam logic [AW-1:0] BUF0 = 32'h0010_0000;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] base_addr = BASE;
    logic run_en = 0, second_frame_en = 0, poll_req = 0, unavail_clr = 0;
    logic rd_req, rd_ack = 0, rd_own = 0, rd_eor = 0;
    logic [AW-1:0] rd_addr, rd_buf_addr = '0, mv_addr, wb_addr;
    logic [LW-1:0] rd_buf_len = '0, mv_len;
    logic mv_start, mv_done = 0, wb_valid, buf_unavail;
    logic [1:0] proc_state;

    txq_proc_ctl uut (.*);

    initial forever #4 clk = ~clk;

    int errs = 0, checks = 0;
    int cyc = 0, lat = 1;
    int n_start = 0, n_wb = 0, n_fetch = 0, max_in = 0;
    int exp_idx = 0, exp_wb = 0, q_n = 0;
    int dq[4];
    bit own[RING];
    logic [AW-1:0] last_fetch = '0, first_fetch = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // memory, mover and monitor models
    initial forever begin
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
        if (!rst_n) begin
            rd_ack = 0; mv_done = 0; q_n = 0;
        end else begin
            if (wb_valid) begin
                int wi;
                wi = int'((wb_addr - BASE) >> 4);
                chk(wi == exp_wb, "R9", "write-back descriptor", wi, exp_wb);
                if (wi >= 0 && wi < RING) own[wi] = 0;
                exp_wb = (exp_wb + 1) % RING;
                n_wb++;
            end
            if (mv_start) begin
                chk(mv_addr == BUF0 + AW'(exp_idx * 256), "R3", "mv_addr", mv_addr,
                    BUF0 + AW'(exp_idx * 256));
                chk(mv_len == LW'(64 + exp_idx), "R3", "mv_len", mv_len, 64 + exp_idx);
                exp_idx = (exp_idx + 1) % RING;
                n_start++;
            end
            if (n_start - n_wb > max_in) max_in = n_start - n_wb;
            mv_done = 0;
            if (q_n > 0 && dq[0] <= cyc) begin
                mv_done = 1;
                for (int k = 0; k < 3; k++) dq[k] = dq[k+1];
                q_n--;
            end
            if (mv_start) begin
                dq[q_n] = cyc + lat;
                q_n++;
            end
            if (rd_ack) rd_ack = 0;
            else if (rd_req) begin
                int ri;
                ri = int'((rd_addr - BASE) >> 4);
                if (n_fetch == 0) first_fetch = rd_addr;
                n_fetch++;
                last_fetch  = rd_addr;
                rd_ack      = 1;
                rd_own      = (ri >= 0 && ri < RING) ? own[ri] : 1'b0;
                rd_eor      = (ri == RING - 1);
                rd_buf_addr = BUF0 + AW'(ri * 256);
                rd_buf_len  = LW'(64 + ri);
            end
        end
    end

    task automatic do_reset();
        rst_n = 0; run_en = 0; poll_req = 0; unavail_clr = 0;
        repeat (3) tick();
        for (int k = 0; k < RING; k++) own[k] = 0;
        n_start = 0; n_wb = 0; n_fetch = 0; max_in = 0;
        exp_idx = 0; exp_wb = 0;
        rst_n = 1;
        tick();
    endtask

    task automatic wait_susp(input string req);
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (proc_state == 2'b10 && n_start == n_wb && !rd_req) begin
                ok = 1;
                break;
            end
        end
        chk(ok, req, "reach Suspended with no frame outstanding", proc_state, 2);
    endtask

    task automatic wait_stop(input string req);
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (proc_state == 2'b00) begin
                ok = 1;
                break;
            end
        end
        chk(ok, req, "reach Stopped", proc_state, 0);
    endtask

    task automatic pulse_poll();
        poll_req = 1; tick(); poll_req = 0;
    endtask

    initial begin
        int nf, ns;
        do_reset();
        // R1 reset state
        chk(proc_state == 2'b00, "R1", "state after reset", proc_state, 0);
        chk(!rd_req && !mv_start && !wb_valid, "R1", "outputs idle", rd_req, 0);
        chk(!buf_unavail, "R1", "flag after reset", buf_unavail, 0);
        // R7 stop and poll ignored while Stopped
        pulse_poll();
        repeat (4) tick();
        chk(n_fetch == 0 && proc_state == 2'b00, "R7", "no read while Stopped", n_fetch, 0);

        // sweep: mode x latency x owned count
        for (int osf = 0; osf < 2; osf++) begin
            for (int li = 0; li < 2; li++) begin
                for (int nown = 0; nown <= RING; nown++) begin
                    do_reset();
                    second_frame_en = osf[0];
                    lat = (li == 0) ? 1 : 4;
                    for (int k = 0; k < nown; k++) own[k] = 1;
                    run_en = 1;
                    tick();
                    chk(proc_state == 2'b01, "R2", "Running after start", proc_state, 1);
                    wait_susp("R4");
                    chk(first_fetch == BASE, "R2", "first read address", first_fetch, BASE);
                    chk(buf_unavail, "R4", "flag on unowned", buf_unavail, 1);
                    chk(n_start == nown, "R3", "frames sent", n_start, nown);
                    chk(n_wb == nown, "R9", "write-backs", n_wb, nown);
                    chk(last_fetch == BASE + AW'(16 * (nown % RING)), "R3",
                        "final ring position", last_fetch, BASE + AW'(16 * (nown % RING)));
                    chk(max_in <= (osf ? 2 : 1), "R8", "outstanding limit", max_in, osf ? 2 : 1);
                    if (osf == 1 && li == 1 && nown >= 2)
                        chk(max_in == 2, "R8", "second frame overlap", max_in, 2);
                end
            end
        end

        // poll, flag clear, stop while Suspended, restart
        do_reset();
        second_frame_en = 1; lat = 2;
        for (int k = 0; k < 3; k++) own[k] = 1;
        run_en = 1;
        wait_susp("R4");
        unavail_clr = 1; tick(); unavail_clr = 0;
        chk(!buf_unavail, "R11", "flag cleared", buf_unavail, 0);
        nf = n_fetch;
        pulse_poll();
        repeat (4) tick();
        chk(n_fetch == nf + 1, "R10", "poll re-reads", n_fetch, nf + 1);
        chk(proc_state == 2'b10 && buf_unavail, "R10", "still Suspended, flag set",
            proc_state, 2);
        own[3] = 1; own[4] = 1;
        pulse_poll();
        wait_susp("R10");
        chk(n_start == 5, "R10", "frames after poll", n_start, 5);
        chk(last_fetch == BASE + 32'h50, "R10", "position after poll", last_fetch, BASE + 32'h50);
        run_en = 0;
        wait_stop("R5");
        nf = n_fetch;
        pulse_poll();
        repeat (4) tick();
        chk(n_fetch == nf && proc_state == 2'b00, "R7", "poll ignored when Stopped", n_fetch, nf);
        own[5] = 1;
        run_en = 1;
        for (int i = 0; i < 50 && n_fetch == nf; i++) tick();
        chk(last_fetch == BASE + 32'h50, "R6", "restart position", last_fetch, BASE + 32'h50);
        wait_susp("R6");
        chk(n_start == 6, "R6", "frames after restart", n_start, 6);

        // stop while Running with a frame in flight
        do_reset();
        second_frame_en = 0; lat = 4;
        for (int k = 0; k < RING; k++) own[k] = 1;
        run_en = 1;
        for (int i = 0; i < 500 && n_start < 2; i++) tick();
        tick();
        run_en = 0;
        tick();
        chk(proc_state == 2'b01, "R5", "still Running while frame in flight", proc_state, 1);
        wait_stop("R5");
        ns = n_start;
        chk(ns == 2, "R5", "frames sent before stop", ns, 2);
        chk(n_wb == ns, "R5", "all frames drained", n_wb, ns);
        run_en = 1;
        wait_susp("R6");
        chk(n_start == RING, "R6", "resumed frames total", n_start, RING);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule